// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device side of a four-wire serial flash interface. It listens on chip select, serial clock and serial data in. It collects an 8-bit command code and, where the command needs one, a 24-bit byte address. It then decides whether an operation starts. Two commands are accepted. Array read (03h) takes an address and then streams bytes from a small on-chip byte array, with the address advancing after every byte. Identification (9Fh) takes no address and streams a fixed three-byte identity. Any other code is rejected, and the rest of the frame is discarded.

The pins are oversampled by the block's own clock, with a synchronizer and edge detection. Both clock polarities used in practice are accepted: idle-low (mode 0) and idle-high (mode 3). Every byte travels most significant bit first. The output is given as a data bit plus an enable that a pad driver turns into a high-impedance state. Single-cycle pulses report a started operation, a rejected code, and a frame cut short. The command code and the captured 21-bit address are held on outputs for the host logic behind the block.

Top module: `flash_cmd_frontend`

## Requirements
- R1: Data in is taken on rising serial-clock edges and data out changes on falling edges. Frames work with the clock idling low (mode 0) and idling high (mode 3).
- R2: After chip select goes low, the first 8 bits taken form the command code. Code, address and data bytes are all sent most significant bit first.
- R3: Code 03h followed by three address bytes gives exactly one op_start_o pulse, with op_code_o = 03h. op_addr_o changes only together with an op_start_o pulse, and at most one of start, abort and reject pulses in any cycle.
- R4: Address bits 23 to 21 are ignored: op_addr_o equals the received address AND 1FFFFFh.
- R5: Read data is the array byte at the current address, and the address increments by one after each byte. The array has 2^ARRAY_AW bytes, indexed by the low ARRAY_AW address bits. With the default configuration, the byte at index i is (37*i + 90) mod 256.
- R6: Code 9Fh needs no address. It pulses op_start_o with op_code_o = 9Fh and streams A5h, 3Ch, 0Fh, then 00h for every later byte.
- R7: Any other code gives one op_reject_o pulse and no op_start_o. All further data in is ignored until chip select cycles: no output is enabled and no further pulse occurs.
- R8: Chip select deasserted after at least one bit but before the command (and, for 03h, its address) is complete gives one op_abort_o pulse and no start. It gives no abort with zero bits, after a complete command, or after a rejected code.
- R9: so_en_o is low while chip select is high and during the code and address phases. It is high during each data-out byte.
- R10: Chip select going high clears all frame state, so the next frame starts again at the command-code phase.
- R11: A synchronous active-high reset drives so_en_o and all pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | block clock used to oversample the serial pins |
| rst_i | input | 1 | synchronous reset, active high |
| cs_n_i | input | 1 | chip select, active low |
| sck_i | input | 1 | serial clock from the host |
| si_i | input | 1 | serial data from the host |
| so_o | output | 1 | serial data to the host |
| so_en_o | output | 1 | output enable for so_o; low means high impedance |
| op_start_o | output | 1 | one-cycle pulse when a valid operation begins |
| op_abort_o | output | 1 | one-cycle pulse when a frame ends with an incomplete command |
| op_reject_o | output | 1 | one-cycle pulse when an unsupported code is received |
| op_code_o | output | 8 | code of the last started operation |
| op_addr_o | output | 21 | masked address of the last started read |

## Verification
Every pin passes through two synchronizer flops and one edge-detect flop, so a serial-clock edge shows up at the outputs three block cycles after it reaches the pins. The bench holds each serial-clock half period for five block cycles. It samples so_o and so_en_o on a falling block-clock edge just before it raises the serial clock, which is two cycles after the data has settled. Event pulses are counted on falling block-clock edges. The counts are compared only after chip select has been high for eight cycles, well after the three-cycle clear.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    PH_OPCODE  = 2'd0,
    PH_ADDR    = 2'd1,
    PH_STREAM  = 2'd2,
    PH_DISCARD = 2'd3
  } phase_e;

  typedef enum logic {
    SRC_ARRAY = 1'b0,
    SRC_IDENT = 1'b1
  } src_e;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_IDENT = 8'h9F;

  // content of the modelled array, computed per index
  function automatic logic [7:0] fill_byte(input int unsigned idx);
    return 8'((idx * 37 + 90) % 256);
  endfunction

endpackage

// File: rtl/fcf_pin_sync.sv
module fcf_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_idle_o,
  output logic si_o
);

  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] si_pipe;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sck_pipe <= '0;
      cs_pipe  <= '1;
      si_pipe  <= '0;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-1:0], sck_i};
      cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_i};
      si_pipe  <= {si_pipe[STAGES-2:0], si_i};
    end
  end

  assign sck_rise_o = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign sck_fall_o = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
  assign cs_idle_o  = cs_pipe[STAGES-1];
  assign si_o       = si_pipe[STAGES-1];

endmodule

// File: rtl/fcf_decoder.sv
module fcf_decoder
  import flash_cmd_pkg::*;
#(
  parameter int CMD_ADDR_W = 24,
  parameter int MAP_ADDR_W = 21,
  parameter int ARRAY_AW   = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  cs_idle_i,
  input  logic                  sck_rise_i,
  input  logic                  si_i,
  input  logic                  byte_take_i,
  output phase_e                phase_o,
  output src_e                  src_o,
  output logic [ARRAY_AW-1:0]   rd_idx_o,
  output logic [1:0]            id_idx_o,
  output logic                  op_start_o,
  output logic                  op_abort_o,
  output logic                  op_reject_o,
  output logic [7:0]            op_code_o,
  output logic [MAP_ADDR_W-1:0] op_addr_o
);

  localparam int CNT_W = $clog2(CMD_ADDR_W);
  localparam logic [CNT_W-1:0] LAST_OPC_BIT  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(CMD_ADDR_W - 1);

  phase_e                  phase_q;
  src_e                    src_q;
  logic [CNT_W-1:0]        bit_cnt_q;
  logic [MAP_ADDR_W-2:0]   sh_q;
  logic [MAP_ADDR_W-1:0]   ptr_q;
  logic [1:0]              id_idx_q;
  logic [7:0]              opc_next;
  logic [MAP_ADDR_W-1:0]   addr_next;

  // upper address bits fall off the shift register and are never kept
  assign opc_next  = {sh_q[6:0], si_i};
  assign addr_next = {sh_q, si_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q     <= PH_OPCODE;
      src_q       <= SRC_ARRAY;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      id_idx_q    <= '0;
      op_start_o  <= 1'b0;
      op_abort_o  <= 1'b0;
      op_reject_o <= 1'b0;
      op_code_o   <= '0;
      op_addr_o   <= '0;
    end else begin
      op_start_o  <= 1'b0;
      op_abort_o  <= 1'b0;
      op_reject_o <= 1'b0;
      if (cs_idle_i) begin
        op_abort_o <= (phase_q == PH_OPCODE && bit_cnt_q != '0) ||
                      (phase_q == PH_ADDR);
        phase_q    <= PH_OPCODE;
        bit_cnt_q  <= '0;
        sh_q       <= '0;
      end else begin
        if (sck_rise_i) begin
          case (phase_q)
            PH_OPCODE: begin
              sh_q <= {sh_q[MAP_ADDR_W-3:0], si_i};
              if (bit_cnt_q == LAST_OPC_BIT) begin
                bit_cnt_q <= '0;
                if (opc_next == OPC_READ) begin
                  phase_q <= PH_ADDR;
                end else if (opc_next == OPC_IDENT) begin
                  phase_q    <= PH_STREAM;
                  src_q      <= SRC_IDENT;
                  id_idx_q   <= '0;
                  op_start_o <= 1'b1;
                  op_code_o  <= opc_next;
                end else begin
                  phase_q     <= PH_DISCARD;
                  op_reject_o <= 1'b1;
                end
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
            PH_ADDR: begin
              sh_q <= {sh_q[MAP_ADDR_W-3:0], si_i};
              if (bit_cnt_q == LAST_ADDR_BIT) begin
                bit_cnt_q  <= '0;
                phase_q    <= PH_STREAM;
                src_q      <= SRC_ARRAY;
                ptr_q      <= addr_next;
                op_addr_o  <= addr_next;
                op_code_o  <= OPC_READ;
                op_start_o <= 1'b1;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (byte_take_i) begin
          if (src_q == SRC_ARRAY) begin
            ptr_q <= ptr_q + 1'b1;
          end else if (id_idx_q != 2'd3) begin
            id_idx_q <= id_idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign phase_o  = phase_q;
  assign src_o    = src_q;
  assign rd_idx_o = ptr_q[ARRAY_AW-1:0];
  assign id_idx_o = id_idx_q;

endmodule

// File: rtl/fcf_array.sv
module fcf_array
  import flash_cmd_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(fill_byte(i));
    end
  end

  always_ff @(posedge clk_i) begin
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/fcf_tx.sv
module fcf_tx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          cs_idle_i,
  input  logic          stream_en_i,
  input  logic          sck_fall_i,
  input  logic [DW-1:0] byte_i,
  output logic          byte_take_o,
  output logic          so_o,
  output logic          so_en_o
);

  localparam int CW = $clog2(DW);

  logic [CW-1:0] left_q;
  logic [DW-1:0] sr_q;

  assign byte_take_o = !cs_idle_i && stream_en_i && sck_fall_i && (left_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i || cs_idle_i) begin
      left_q  <= '0;
      sr_q    <= '0;
      so_o    <= 1'b0;
      so_en_o <= 1'b0;
    end else if (stream_en_i && sck_fall_i) begin
      so_en_o <= 1'b1;
      if (left_q == '0) begin
        so_o   <= byte_i[DW-1];
        sr_q   <= {byte_i[DW-2:0], 1'b0};
        left_q <= CW'(DW - 1);
      end else begin
        so_o   <= sr_q[DW-1];
        sr_q   <= {sr_q[DW-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_cmd_pkg::*;
#(
  parameter int          ARRAY_AW    = 6,
  parameter int          SYNC_STAGES = 2,
  parameter int          CMD_ADDR_W  = 24,
  parameter int          MAP_ADDR_W  = 21,
  parameter logic [23:0] ID_WORD     = 24'hA53C0F
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  cs_n_i,
  input  logic                  sck_i,
  input  logic                  si_i,
  output logic                  so_o,
  output logic                  so_en_o,
  output logic                  op_start_o,
  output logic                  op_abort_o,
  output logic                  op_reject_o,
  output logic [7:0]            op_code_o,
  output logic [MAP_ADDR_W-1:0] op_addr_o
);

  localparam int DW = 8;

  logic                sck_rise, sck_fall, cs_idle, si_s;
  logic                byte_take;
  phase_e              phase;
  src_e                src;
  logic [ARRAY_AW-1:0] rd_idx;
  logic [1:0]          id_idx;
  logic [DW-1:0]       arr_byte;
  logic [DW-1:0]       id_byte;
  logic [DW-1:0]       out_byte;

  fcf_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sck_i      (sck_i),
    .cs_n_i     (cs_n_i),
    .si_i       (si_i),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .cs_idle_o  (cs_idle),
    .si_o       (si_s)
  );

  fcf_decoder #(
    .CMD_ADDR_W (CMD_ADDR_W),
    .MAP_ADDR_W (MAP_ADDR_W),
    .ARRAY_AW   (ARRAY_AW)
  ) u_dec (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cs_idle_i   (cs_idle),
    .sck_rise_i  (sck_rise),
    .si_i        (si_s),
    .byte_take_i (byte_take),
    .phase_o     (phase),
    .src_o       (src),
    .rd_idx_o    (rd_idx),
    .id_idx_o    (id_idx),
    .op_start_o  (op_start_o),
    .op_abort_o  (op_abort_o),
    .op_reject_o (op_reject_o),
    .op_code_o   (op_code_o),
    .op_addr_o   (op_addr_o)
  );

  fcf_array #(.AW(ARRAY_AW), .DW(DW)) u_arr (
    .clk_i   (clk_i),
    .raddr_i (rd_idx),
    .rdata_o (arr_byte)
  );

  always_comb begin
    case (id_idx)
      2'd0:    id_byte = ID_WORD[23:16];
      2'd1:    id_byte = ID_WORD[15:8];
      2'd2:    id_byte = ID_WORD[7:0];
      default: id_byte = '0;
    endcase
  end

  assign out_byte = (src == SRC_IDENT) ? id_byte : arr_byte;

  fcf_tx #(.DW(DW)) u_tx (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cs_idle_i   (cs_idle),
    .stream_en_i (phase == PH_STREAM),
    .sck_fall_i  (sck_fall),
    .byte_i      (out_byte),
    .byte_take_o (byte_take),
    .so_o        (so_o),
    .so_en_o     (so_en_o)
  );

endmodule

// File: rtl/flash_cmd_frontend_chk.sv
module flash_cmd_frontend_chk #(
  parameter int MAP_ADDR_W = 21
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  cs_n_i,
  input logic                  so_en_o,
  input logic                  op_start_o,
  input logic                  op_abort_o,
  input logic                  op_reject_o,
  input logic [MAP_ADDR_W-1:0] op_addr_o
);

  logic [2:0] cs_hi_cnt;
  logic       rej_seen;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cs_hi_cnt <= '0;
      rej_seen  <= 1'b0;
    end else begin
      if (!cs_n_i)               cs_hi_cnt <= '0;
      else if (cs_hi_cnt != 3'd7) cs_hi_cnt <= cs_hi_cnt + 1'b1;
      if (op_reject_o)           rej_seen <= 1'b1;
      else if (cs_hi_cnt >= 3'd3) rej_seen <= 1'b0;
    end
  end

  // R3: start, abort and reject never coincide
  a_r3_one_event: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({op_start_o, op_abort_o, op_reject_o}));

  // R3: captured address moves only with a start pulse
  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(op_addr_o) |-> op_start_o);

  // R8: an abort only follows release of chip select
  a_r8_abort_on_release: assert property (@(posedge clk_i) disable iff (rst_i)
    op_abort_o |-> cs_hi_cnt >= 3'd2);

  // R9: output released once chip select has been high a while
  a_r9_released_when_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    cs_hi_cnt >= 3'd4 |-> !so_en_o);

  // R7: nothing is driven for the rest of a rejected frame
  a_r7_quiet_after_reject: assert property (@(posedge clk_i) disable iff (rst_i)
    rej_seen |-> !so_en_o);

endmodule

bind flash_cmd_frontend flash_cmd_frontend_chk #(.MAP_ADDR_W(MAP_ADDR_W)) chk_i (.*);

// File: tb/flash_cmd_frontend_tb_top.sv
module flash_cmd_frontend_tb_top;

  localparam int HP = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        si = 1'b0;
  logic        so_o, so_en_o, op_start_o, op_abort_o, op_reject_o;
  logic [7:0]  op_code_o;
  logic [20:0] op_addr_o;

  int checks = 0;
  int errors = 0;
  int n_start = 0, n_abort = 0, n_reject = 0;
  logic [7:0]  last_code = '0;
  logic [20:0] last_addr = '0;

  always #5 clk = ~clk;

  flash_cmd_frontend dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .cs_n_i      (cs_n),
    .sck_i       (sck),
    .si_i        (si),
    .so_o        (so_o),
    .so_en_o     (so_en_o),
    .op_start_o  (op_start_o),
    .op_abort_o  (op_abort_o),
    .op_reject_o (op_reject_o),
    .op_code_o   (op_code_o),
    .op_addr_o   (op_addr_o)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (op_start_o) begin
        n_start++;
        last_code = op_code_o;
        last_addr = op_addr_o;
      end
      if (op_abort_o)  n_abort++;
      if (op_reject_o) n_reject++;
    end
  end

  function automatic logic [7:0] exp_byte(input logic [31:0] a);
    return 8'((((a & 32'h3F) * 37) + 90) & 32'hFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame_begin(input logic mode3);
    sck  <= mode3;
    @(posedge clk);
    cs_n <= 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic frame_end(input logic mode3);
    if (!mode3) begin
      sck <= 1'b0;
      repeat (HP) @(posedge clk);
    end
    cs_n <= 1'b1;
    repeat (8) @(posedge clk);
  endtask

  // one bit: falling edge, present data, sample SO, rising edge
  task automatic xfer_bit(input logic b, output logic rx, output logic en);
    sck <= 1'b0;
    si  <= b;
    repeat (HP - 1) @(posedge clk);
    @(negedge clk);
    rx = so_o;
    en = so_en_o;
    @(posedge clk);
    sck <= 1'b1;
    repeat (HP) @(posedge clk);
  endtask

  task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx,
                           output logic en_any, output logic en_all);
    logic r, e;
    en_any = 1'b0;
    en_all = 1'b1;
    for (int b = 7; b >= 0; b--) begin
      xfer_bit(tx[b], r, e);
      rx[b]  = r;
      en_any = en_any | e;
      en_all = en_all & e;
    end
  endtask

  task automatic do_read(input logic mode3, input logic [23:0] addr, input int nbytes);
    logic [7:0] rx;
    logic ea, el;
    int s0, a0;
    s0 = n_start; a0 = n_abort;
    frame_begin(mode3);
    xfer_byte(8'h03, rx, ea, el);
    chk("R9 no drive in code phase", ea, 0);
    for (int k = 2; k >= 0; k--) begin
      xfer_byte(addr[8*k +: 8], rx, ea, el);
      chk("R9 no drive in address phase", ea, 0);
    end
    for (int i = 0; i < nbytes; i++) begin
      xfer_byte(8'h00, rx, ea, el);
      chk(mode3 ? "R5 R1 read byte mode3" : "R5 R1 read byte mode0",
          rx, exp_byte(32'(addr) + 32'(i)));
      chk("R9 drive during data", el, 1);
    end
    frame_end(mode3);
    chk("R3 one start", n_start - s0, 1);
    chk("R3 code", last_code, 8'h03);
    chk("R4 masked address", last_addr, 32'(addr) & 32'h1FFFFF);
    chk("R8 no abort on complete", n_abort - a0, 0);
    chk("R9 released after frame", so_en_o, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] rx;
    logic ea, el, r, e;
    int s0, a0, j0;

    repeat (4) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk("R11 reset so_en", so_en_o, 0);
    chk("R11 reset pulses", {op_start_o, op_abort_o, op_reject_o}, 0);
    repeat (4) @(posedge clk);

    // R4 R5 R1: reads at spread addresses, both clock polarities
    do_read(1'b0, 24'h000000, 4);
    do_read(1'b1, 24'hFFFFFF, 3);
    do_read(1'b0, 24'h1FFFFE, 3);
    for (int k = 1; k <= 20; k++) begin
      do_read(k[0], 24'((k * 32'h00A5F1B3) & 32'hFFFFFF), 3);
    end

    // R6: identity stream in both modes
    for (int m = 0; m < 2; m++) begin
      s0 = n_start;
      frame_begin(m[0]);
      xfer_byte(8'h9F, rx, ea, el);
      chk("R6 no drive during code", ea, 0);
      xfer_byte(8'h00, rx, ea, el); chk("R6 id byte 0", rx, 8'hA5);
      xfer_byte(8'h00, rx, ea, el); chk("R6 id byte 1", rx, 8'h3C);
      xfer_byte(8'h00, rx, ea, el); chk("R6 id byte 2", rx, 8'h0F);
      xfer_byte(8'h00, rx, ea, el); chk("R6 id tail", rx, 8'h00);
      xfer_byte(8'h00, rx, ea, el); chk("R6 id tail again", rx, 8'h00);
      chk("R9 drive during id", el, 1);
      frame_end(m[0]);
      chk("R6 one start", n_start - s0, 1);
      chk("R6 code", last_code, 8'h9F);
    end

    // R2 R7 R8: sweep every code value followed by a read code byte
    for (int op = 0; op < 256; op++) begin
      s0 = n_start; a0 = n_abort; j0 = n_reject;
      frame_begin(op[0]);
      xfer_byte(8'(op), rx, ea, el);
      xfer_byte(8'h03, rx, ea, el);
      frame_end(op[0]);
      if (op == 8'h03) begin
        chk("R8 abort in address phase", n_abort - a0, 1);
        chk("R8 no start", n_start - s0, 0);
        chk("R9 no drive in address", ea, 0);
      end else if (op == 8'h9F) begin
        chk("R2 id start", n_start - s0, 1);
        chk("R6 first id byte", rx, 8'hA5);
      end else begin
        chk("R7 reject", n_reject - j0, 1);
        chk("R7 no start", n_start - s0, 0);
        chk("R7 later data ignored", ea, 0);
        chk("R8 no abort after reject", n_abort - a0, 0);
      end
    end

    // R8: partial code bits
    for (int nb = 1; nb <= 7; nb++) begin
      a0 = n_abort; s0 = n_start;
      frame_begin(nb[0]);
      for (int b = 0; b < nb; b++) xfer_bit(1'b0, r, e);
      frame_end(nb[0]);
      chk("R8 abort partial code", n_abort - a0, 1);
      chk("R8 partial no start", n_start - s0, 0);
    end

    // R8: chip select pulse with no clocks
    a0 = n_abort;
    frame_begin(1'b0);
    frame_end(1'b0);
    chk("R8 no abort on empty frame", n_abort - a0, 0);

    // R8: code plus one and two address bytes
    for (int nb = 1; nb <= 2; nb++) begin
      a0 = n_abort; s0 = n_start;
      frame_begin(1'b1);
      xfer_byte(8'h03, rx, ea, el);
      for (int b = 0; b < nb; b++) xfer_byte(8'h12, rx, ea, el);
      frame_end(1'b1);
      chk("R8 abort short address", n_abort - a0, 1);
      chk("R8 short address no start", n_start - s0, 0);
    end

    // R10: a clean read right after an abort
    frame_begin(1'b0);
    for (int b = 0; b < 5; b++) xfer_bit(1'b1, r, e);
    frame_end(1'b0);
    do_read(1'b0, 24'h000021, 2);
    chk("R10 fresh frame address", last_addr, 21'h000021);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule